// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may advance. Branches in this pipeline are compared in the decode stage. The unit looks at the two source register numbers of the instruction in decode and at the destination, load and register-write flags of the instructions in execute and memory. It raises a stall when a value cannot yet be forwarded in time.

A stall holds the program counter and the fetch/decode register. It also forces a bubble into the decode/execute register, so the later stages do nothing for that slot. The pipeline itself does not change between checks: the producers move down one stage each cycle. As a result, the unit needs no state of its own. A load followed by a dependent ALU instruction stalls once. A load directly before a dependent branch stalls twice, because the load is first seen in execute and then in memory.

When the decode stage resolves a branch as taken and no stall is pending, the unit flushes the wrongly fetched instruction from the fetch/decode register.

Top module: `hazard_unit`

## Requirements
- R1: When the execute-stage producer has both load and register-write set and a non-zero destination equal to the decode rs or rt, the unit outputs pc_we=0, ifid_we=0 and idex_bubble=1.
- R2: A destination of register 0 never causes a stall, whatever the other flags are.
- R3: A producer whose register-write flag is 0 never causes a stall.
- R4: A branch in decode stalls when the execute-stage producer writes a non-zero register that matches rs or rt, even when that producer is not a load.
- R5: A branch in decode stalls when the memory-stage producer is a load (load and register-write set) whose non-zero destination matches rs or rt.
- R6: A branch whose match is only with a memory-stage producer that is not a load does not stall.
- R7: With no stall pending, a branch in decode with branch_taken=1 gives ifid_flush=1 while pc_we=1 and ifid_we=1.
- R8: A stall takes priority over a flush: ifid_flush is 0 in any cycle with idex_bubble=1.
- R9: With no hazard and no taken branch, the outputs are pc_we=1, ifid_we=1, idex_bubble=0, ifid_flush=0.
- R10: A load directly followed by a dependent branch gives exactly two stall cycles as the pipeline advances. The flush then comes in the third cycle.
- R11: A non-branch instruction does not stall on a memory-stage load. That value reaches it through forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used by the embedded checks |
| rst_n | input | 1 | Active-low reset; disables the embedded checks |
| id_rs | input | REG_W | First source register of the decode-stage instruction |
| id_rt | input | REG_W | Second source register of the decode-stage instruction |
| id_is_branch | input | 1 | Decode-stage instruction is a conditional branch |
| id_branch_taken | input | 1 | Branch outcome from the decode-stage comparator |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields entering decode/execute |
| ifid_flush | output | 1 | Zero the fetch/decode register (taken branch) |

## Verification
The hardest case is the two-cycle branch stall after a load. It only appears when the same load is seen first in execute and then in memory, while the branch is held in decode. The bench drives this as a short pipeline replay: the load moves into memory and a bubble fills execute, exactly as a held pipeline would present them. Randomised stimulus drawn from four register numbers makes rs/rt/destination collisions, including register 0, frequent. A behavioural model checks every cycle of it.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        HZ_NONE      = 2'd0,
        HZ_LOAD_USE  = 2'd1,
        HZ_BR_EX     = 2'd2,
        HZ_BR_MEMLD  = 2'd3
    } hz_cause_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
        logic flush;
    } hz_ctl_t;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_W-1:0]              dst,
    input  logic                          wr_en,
    input  logic [NUM_SRC-1:0][REG_W-1:0] srcs,
    output logic                          hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] eq_d;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign eq_d[s] = (srcs[s] == dst);
    end

    assign hit = wr_en && (dst != ZERO_REG) && (|eq_d);

endmodule

// File: rtl/hz_resolve.sv
module hz_resolve
    import hz_pkg::*;
(
    input  logic    ex_hit,
    input  logic    ex_is_load,
    input  logic    mem_hit,
    input  logic    mem_is_load,
    input  logic    is_branch,
    input  logic    branch_taken,
    output hz_ctl_t ctl
);
    hz_cause_e cause_d;
    hz_ctl_t   ctl_d;

    always_comb begin
        cause_d = HZ_NONE;
        if (ex_hit && ex_is_load)
            cause_d = HZ_LOAD_USE;
        else if (is_branch && ex_hit)
            cause_d = HZ_BR_EX;
        else if (is_branch && mem_hit && mem_is_load)
            cause_d = HZ_BR_MEMLD;

        ctl_d = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0, flush: 1'b0};
        if (cause_d != HZ_NONE) begin
            ctl_d.pc_we   = 1'b0;
            ctl_d.ifid_we = 1'b0;
            ctl_d.bubble  = 1'b1;
        end else if (is_branch && branch_taken) begin
            ctl_d.flush = 1'b1;
        end
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_is_branch,
    input  logic             id_branch_taken,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_mem_read,
    input  logic             ex_reg_write,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_mem_read,
    input  logic             mem_reg_write,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble,
    output logic             ifid_flush
);
    localparam int NUM_SRC = 2;
    localparam int NUM_PRD = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] srcs;
    logic [NUM_PRD-1:0][REG_W-1:0] prd_dst;
    logic [NUM_PRD-1:0]            prd_we;
    logic [NUM_PRD-1:0]            prd_hit;
    hz_ctl_t                       ctl;

    assign srcs    = {id_rt, id_rs};
    assign prd_dst = {mem_dst, ex_dst};
    assign prd_we  = {mem_reg_write, ex_reg_write};

    for (genvar p = 0; p < NUM_PRD; p++) begin : g_prd
        hz_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_match (
            .dst   (prd_dst[p]),
            .wr_en (prd_we[p]),
            .srcs  (srcs),
            .hit   (prd_hit[p])
        );
    end

    hz_resolve u_resolve (
        .ex_hit       (prd_hit[0]),
        .ex_is_load   (ex_mem_read),
        .mem_hit      (prd_hit[1]),
        .mem_is_load  (mem_mem_read),
        .is_branch    (id_is_branch),
        .branch_taken (id_branch_taken),
        .ctl          (ctl)
    );

    assign pc_we       = ctl.pc_we;
    assign ifid_we     = ctl.ifid_we;
    assign idex_bubble = ctl.bubble;
    assign ifid_flush  = ctl.flush;

    p_loaduse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && ex_reg_write && ex_dst != '0 && (ex_dst == id_rs || ex_dst == id_rt))
        |-> (idex_bubble && !pc_we && !ifid_we));

    p_zero_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0 && mem_dst == '0) |-> (pc_we && !idex_bubble));

    p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_reg_write && !mem_reg_write) |-> (ifid_we && !idex_bubble));

    p_nonload_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_reg_write && !mem_mem_read) |-> pc_we);

    p_flush_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> !ifid_flush);

    p_taken_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && id_branch_taken && pc_we) |-> ifid_flush);

endmodule

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [RW-1:0] id_rs, id_rt, ex_dst, mem_dst;
    logic id_is_branch, id_branch_taken;
    logic ex_mem_read, ex_reg_write, mem_mem_read, mem_reg_write;
    logic pc_we, ifid_we, idex_bubble, ifid_flush;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    hazard_unit #(.REG_W(RW)) u_hazard_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt),
        .id_is_branch(id_is_branch), .id_branch_taken(id_branch_taken),
        .ex_dst(ex_dst), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
        .mem_dst(mem_dst), .mem_mem_read(mem_mem_read), .mem_reg_write(mem_reg_write),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    // Behavioural reference: {pc_we, ifid_we, bubble, flush}
    function automatic logic [3:0] model();
        bit need_wait = 0;
        int src [2];
        src[0] = int'(id_rs);
        src[1] = int'(id_rt);
        foreach (src[i]) begin
            if (ex_reg_write && ex_dst != 0 && int'(ex_dst) == src[i]) begin
                if (ex_mem_read || id_is_branch) need_wait = 1;
            end
            if (id_is_branch && mem_mem_read && mem_reg_write && mem_dst != 0
                && int'(mem_dst) == src[i]) need_wait = 1;
        end
        if (need_wait) return 4'b0010;
        if (id_is_branch && id_branch_taken) return 4'b1101;
        return 4'b1100;
    endfunction

    task automatic put(input int rs, input int rt, input bit br, input bit tk,
                       input int ed, input bit emr, input bit erw,
                       input int md, input bit mmr, input bit mrw);
        @(negedge clk);
        id_rs = RW'(rs); id_rt = RW'(rt); id_is_branch = br; id_branch_taken = tk;
        ex_dst = RW'(ed); ex_mem_read = emr; ex_reg_write = erw;
        mem_dst = RW'(md); mem_mem_read = mmr; mem_reg_write = mrw;
        #1;
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {pc_we, ifid_we, idex_bubble, ifid_flush};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic step(input string req, input logic [3:0] exp,
                        input int rs, input int rt, input bit br, input bit tk,
                        input int ed, input bit emr, input bit erw,
                        input int md, input bit mmr, input bit mrw);
        put(rs, rt, br, tk, ed, emr, erw, md, mmr, mrw);
        check(req, exp);
        check({req, "_model"}, model());
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R9_reset", 4'b1100);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        step("R1_rs",      4'b0010, 3, 7, 0, 0, 3, 1, 1, 0, 0, 0);
        step("R1_rt",      4'b0010, 6, 3, 0, 0, 3, 1, 1, 0, 0, 0);
        step("R2",         4'b1100, 0, 0, 1, 0, 0, 1, 1, 0, 1, 1);
        step("R3",         4'b1100, 3, 3, 1, 0, 3, 1, 0, 3, 1, 0);
        step("R4",         4'b0010, 4, 9, 1, 0, 4, 0, 1, 0, 0, 0);
        step("R5",         4'b0010, 9, 4, 1, 0, 0, 0, 0, 4, 1, 1);
        step("R6",         4'b1100, 4, 9, 1, 0, 0, 0, 0, 4, 0, 1);
        step("R6_R7",      4'b1101, 4, 9, 1, 1, 0, 0, 0, 4, 0, 1);
        step("R11",        4'b1100, 4, 9, 0, 0, 0, 0, 0, 4, 1, 1);
        step("R7",         4'b1101, 2, 5, 1, 1, 8, 0, 1, 9, 1, 1);
        step("R8",         4'b0010, 4, 5, 1, 1, 4, 0, 1, 0, 0, 0);
        step("R9",         4'b1100, 1, 2, 0, 0, 3, 1, 1, 4, 1, 1);
        // R10 pipeline replay: load r1 then branch on r1, pipeline held twice
        step("R10_cyc1",   4'b0010, 1, 2, 1, 1, 1, 1, 1, 0, 0, 0);
        step("R10_cyc2",   4'b0010, 1, 2, 1, 1, 0, 0, 0, 1, 1, 1);
        step("R10_cyc3",   4'b1101, 1, 2, 1, 1, 0, 0, 0, 0, 0, 0);

        for (int k = 0; k < 600; k++) begin
            put($urandom_range(0, 3), $urandom_range(0, 3),
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                $urandom_range(0, 3), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                $urandom_range(0, 3), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
            check("R1_R4_R5_R8_random", model());
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule